// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block turns the CPU's low address byte and two latched I/O port values into memory selects and full addresses for a small 8-bit handheld system. Program space is 4 KB. The top four program address lines come from the low nibble of port 2, not from the CPU bus. A control bit in port 1 chooses what the bottom kilobyte of program space shows. When the bit is 0 it is an internal boot ROM. When the bit is 1 it is the matching cartridge offsets. External RAM is split into four 256-byte pages, and two port-1 bits choose the page. Pages 1 to 3 hold the display columns. The decoder reports which video bank is addressed and which range of columns that bank covers.

Both port latches sit inside the block. They load on a write strobe at the clock edge and come out of reset holding all ones. Everything after the latches is combinational. Two request inputs describe the current CPU access: a program fetch or an external RAM access. At most one memory select is active at any time.

Top module: `banked_mem_decoder`

## Requirements
- R1: After reset the port-1 latch holds 3'b111 and the port-2 latch holds 4'hF. As a result, a program fetch at low byte 8'h00 selects the cartridge at ROM address 12'hF00, and the RAM page is 3.
- R2: The ROM address always equals {port-2 latch bits 3:0, cpu_addr}.
- R3: With port-1 bit 2 at 0, a program fetch whose ROM address is below 12'h400 asserts boot_sel only. 12'h3FF is the last such address.
- R4: With port-1 bit 2 at 1, a program fetch below 12'h400 asserts cart_sel and not boot_sel.
- R5: A program fetch at ROM address 12'h400 or above asserts cart_sel, whatever port-1 bit 2 holds.
- R6: The RAM address always equals {port-1 latch bits 1:0, cpu_addr}. xram_sel is high when ram_rd is high and rom_rd is low.
- R7: At most one of boot_sel, cart_sel and xram_sel is high. All three are low when no request is made.
- R8: video_flag is high only when xram_sel is high and the page is not 0. video_bank then equals the page (1, 2 or 3). Otherwise video_bank is 0.
- R9: While video_flag is high, col_first equals (page-1)*50+1 and col_last equals page*50. While it is low, both are 0.
- R10: A write strobe loads its own latch at the next rising clock edge and leaves the other latch unchanged.
- R11: When rom_rd and ram_rd are high together, the program fetch wins and xram_sel stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the port latches |
| rst_n | input | 1 | Synchronous active-low reset |
| p1_we | input | 1 | Load strobe for the port-1 latch |
| p1_wdata | input | 3 | Port-1 bits 2:0. Bit 2 turns off the boot overlay. Bits 1:0 choose the RAM page |
| p2_we | input | 1 | Load strobe for the port-2 latch |
| p2_wdata | input | 4 | Port-2 bits 3:0, the upper program address lines |
| cpu_addr | input | 8 | CPU low address byte |
| rom_rd | input | 1 | Program fetch request |
| ram_rd | input | 1 | External RAM access request |
| boot_sel | output | 1 | Boot ROM select |
| cart_sel | output | 1 | Cartridge ROM select |
| xram_sel | output | 1 | External RAM select |
| rom_addr | output | 12 | Full program address |
| ram_addr | output | 10 | Full external RAM address |
| video_flag | output | 1 | The addressed RAM page is a video bank |
| video_bank | output | 2 | Video bank index, 1 to 3 |
| col_first | output | 8 | First display column of the bank |
| col_last | output | 8 | Last display column of the bank |

## Verification
A wrong latch value shows up in the same cycle as a wrong rom_addr or ram_addr upper field. It can also show up as a boot/cartridge swap on fetches in the bottom kilobyte. Any access after the faulty latch edge exposes it. Because the mapping logic is combinational, a fault there shows on the first request that reaches the faulty case. The bench therefore hits each of these: both sides of the 12'h3FF/12'h400 boundary, every RAM page, and both request lines at once.

// File: rtl/bd_pkg.sv
// Package: shared widths and the access-target type for the banked decoder.
// Assumes: 8-bit CPU low address and a 4 KB program space.
package bd_pkg;
    localparam int LOW_AW  = 8;
    localparam int HI_AW   = 4;
    localparam int ROM_AW  = LOW_AW + HI_AW;
    localparam int BOOT_AW = 10;
    localparam int PAGE_W  = 2;
    localparam int RAM_AW  = LOW_AW + PAGE_W;
    localparam int CTRL_W  = PAGE_W + 1;
    localparam int COL_W   = 8;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_BOOT = 2'd1,
        TGT_CART = 2'd2,
        TGT_XRAM = 2'd3
    } tgt_e;
endpackage

// File: rtl/bd_port_reg.sv
// Module: bd_port_reg
// Holds one port value. It loads on a write strobe and resets to all ones.
// Assumes: a synchronous active-low reset.
module bd_port_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Purpose: reset to all ones, otherwise load on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '1;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/bd_prog_map.sv
// Module: bd_prog_map
// Builds the full program address and picks boot ROM or cartridge.
// Assumes: the boot overlay covers the lowest 2**BOOT_AW bytes.
module bd_prog_map
    import bd_pkg::*;
#(
    parameter int LAW = LOW_AW,
    parameter int HAW = HI_AW,
    parameter int BAW = BOOT_AW,
    localparam int AW = LAW + HAW
) (
    input  logic           rom_rd,
    input  logic           boot_off,
    input  logic [HAW-1:0] hi_bits,
    input  logic [LAW-1:0] lo_bits,
    output logic [AW-1:0]  addr,
    output tgt_e           tgt
);
    logic in_low;

    // Purpose: join the port nibble and the CPU byte into the program address.
    always_comb addr = {hi_bits, lo_bits};

    // Purpose: detect the overlay window at the bottom of program space.
    always_comb in_low = (addr[AW-1:BAW] == '0);

    // Purpose: choose the target of a program fetch.
    always_comb begin
        if (!rom_rd)                 tgt = TGT_NONE;
        else if (in_low && !boot_off) tgt = TGT_BOOT;
        else                         tgt = TGT_CART;
    end
endmodule

// File: rtl/bd_xram_map.sv
// Module: bd_xram_map
// Builds the external RAM address and reports video-bank information.
// Assumes: page 0 is general storage, and pages 1..NPAGE-1 each hold COLS columns.
module bd_xram_map
    import bd_pkg::*;
#(
    parameter int LAW  = LOW_AW,
    parameter int PW   = PAGE_W,
    parameter int CW   = COL_W,
    parameter int COLS = 50,
    localparam int AW  = LAW + PW
) (
    input  logic           ram_req,
    input  logic [PW-1:0]  page,
    input  logic [LAW-1:0] lo_bits,
    output logic [AW-1:0]  addr,
    output logic           vflag,
    output logic [PW-1:0]  vbank,
    output logic [CW-1:0]  cfirst,
    output logic [CW-1:0]  clast
);
    localparam int NPAGE = 1 << PW;

    logic [CW-1:0] first_tab [NPAGE];
    logic [CW-1:0] last_tab  [NPAGE];

    // One column-range entry per page. Page 0 carries no range.
    for (genvar g = 0; g < NPAGE; g++) begin : g_cols
        if (g == 0) begin : g_store
            assign first_tab[g] = '0;
            assign last_tab[g]  = '0;
        end else begin : g_video
            assign first_tab[g] = CW'((g - 1) * COLS + 1);
            assign last_tab[g]  = CW'(g * COLS);
        end
    end

    // Purpose: join the page and the CPU byte into the RAM address.
    always_comb addr = {page, lo_bits};

    // Purpose: flag a video bank and give its index and column range.
    always_comb begin
        vflag  = ram_req && (page != '0);
        vbank  = vflag ? page : '0;
        cfirst = vflag ? first_tab[page] : '0;
        clast  = vflag ? last_tab[page]  : '0;
    end
endmodule

// File: rtl/banked_mem_decoder.sv
// Module: banked_mem_decoder (top)
// Holds the port latches and decodes program and RAM accesses into selects and addresses.
// Assumes: rom_rd and ram_rd describe the current CPU access. A program fetch takes priority.
module banked_mem_decoder
    import bd_pkg::*;
#(
    parameter int COLS_PER_BANK = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p1_we,
    input  logic [CTRL_W-1:0] p1_wdata,
    input  logic              p2_we,
    input  logic [HI_AW-1:0]  p2_wdata,
    input  logic [LOW_AW-1:0] cpu_addr,
    input  logic              rom_rd,
    input  logic              ram_rd,
    output logic              boot_sel,
    output logic              cart_sel,
    output logic              xram_sel,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              video_flag,
    output logic [PAGE_W-1:0] video_bank,
    output logic [COL_W-1:0]  col_first,
    output logic [COL_W-1:0]  col_last
);
    logic [CTRL_W-1:0] p1_q;
    logic [HI_AW-1:0]  p2_q;
    tgt_e              prog_tgt;
    logic              ram_req;

    bd_port_reg #(.W(CTRL_W)) u_p1 (
        .clk(clk), .rst_n(rst_n), .we(p1_we), .wdata(p1_wdata), .q(p1_q)
    );

    bd_port_reg #(.W(HI_AW)) u_p2 (
        .clk(clk), .rst_n(rst_n), .we(p2_we), .wdata(p2_wdata), .q(p2_q)
    );

    bd_prog_map #(.LAW(LOW_AW), .HAW(HI_AW), .BAW(BOOT_AW)) u_prog (
        .rom_rd(rom_rd), .boot_off(p1_q[CTRL_W-1]), .hi_bits(p2_q),
        .lo_bits(cpu_addr), .addr(rom_addr), .tgt(prog_tgt)
    );

    // Purpose: a RAM access only counts when no program fetch is pending.
    always_comb ram_req = ram_rd && !rom_rd;

    bd_xram_map #(.LAW(LOW_AW), .PW(PAGE_W), .CW(COL_W), .COLS(COLS_PER_BANK)) u_xram (
        .ram_req(ram_req), .page(p1_q[PAGE_W-1:0]), .lo_bits(cpu_addr),
        .addr(ram_addr), .vflag(video_flag), .vbank(video_bank),
        .cfirst(col_first), .clast(col_last)
    );

    // Purpose: expand the chosen target into one-hot select lines.
    always_comb begin
        boot_sel = (prog_tgt == TGT_BOOT);
        cart_sel = (prog_tgt == TGT_CART);
        xram_sel = ram_req;
    end
endmodule

// File: rtl/banked_mem_decoder_chk.sv
// Module: banked_mem_decoder_chk
// Assertion checker bound to banked_mem_decoder.
// Assumes: it observes the port-1 latch value through a bound internal signal.
module banked_mem_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        p1_we,
    input logic [2:0]  p1_wdata,
    input logic        rom_rd,
    input logic        ram_rd,
    input logic        boot_sel,
    input logic        cart_sel,
    input logic        xram_sel,
    input logic [11:0] rom_addr,
    input logic [9:0]  ram_addr,
    input logic        video_flag,
    input logic [1:0]  video_bank,
    input logic [2:0]  p1_q
);
    p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({boot_sel, cart_sel, xram_sel}));

    p_boot_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        boot_sel |-> (rom_addr[11:10] == 2'b00 && !p1_q[2] && rom_rd));

    p_boot_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd && p1_q[2]) |-> (!boot_sel && cart_sel));

    p_high_cart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd && rom_addr[11:10] != 2'b00) |-> cart_sel);

    p_page_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        p1_we |=> (ram_addr[9:8] == $past(p1_wdata[1:0])));

    p_video_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        video_flag |-> (xram_sel && video_bank == ram_addr[9:8] && video_bank != 2'd0));

    p_fetch_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd && ram_rd) |-> !xram_sel);
endmodule

bind banked_mem_decoder banked_mem_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .p1_we(p1_we), .p1_wdata(p1_wdata),
    .rom_rd(rom_rd), .ram_rd(ram_rd), .boot_sel(boot_sel), .cart_sel(cart_sel),
    .xram_sel(xram_sel), .rom_addr(rom_addr), .ram_addr(ram_addr),
    .video_flag(video_flag), .video_bank(video_bank), .p1_q(p1_q)
);

// File: tb/banked_mem_decoder_test.sv
// Bench: scoreboard. The driver pushes expected output vectors and the monitor compares them.
module banked_mem_decoder_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        p1_we = 1'b0, p2_we = 1'b0;
    logic [2:0]  p1_wdata = '0;
    logic [3:0]  p2_wdata = '0;
    logic [7:0]  cpu_addr = '0;
    logic        rom_rd = 1'b0, ram_rd = 1'b0;
    logic        boot_sel, cart_sel, xram_sel, video_flag;
    logic [11:0] rom_addr;
    logic [9:0]  ram_addr;
    logic [1:0]  video_bank;
    logic [7:0]  col_first, col_last;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [43:0] vec;
        string       req;
    } exp_t;
    exp_t exp_q[$];
    event sample_ev;

    // Bench-side copies of the latch contents, updated from the stimulus.
    logic [2:0] m_p1 = 3'b111;
    logic [3:0] m_p2 = 4'hF;

    banked_mem_decoder uut (
        .clk(clk), .rst_n(rst_n), .p1_we(p1_we), .p1_wdata(p1_wdata),
        .p2_we(p2_we), .p2_wdata(p2_wdata), .cpu_addr(cpu_addr),
        .rom_rd(rom_rd), .ram_rd(ram_rd), .boot_sel(boot_sel),
        .cart_sel(cart_sel), .xram_sel(xram_sel), .rom_addr(rom_addr),
        .ram_addr(ram_addr), .video_flag(video_flag), .video_bank(video_bank),
        .col_first(col_first), .col_last(col_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected outputs, worked out from the requirements.
    function automatic logic [43:0] model(logic [7:0] a, logic rr, logic xr);
        logic [11:0] ra = {m_p2, a};
        logic [9:0]  xa = {m_p1[1:0], a};
        logic b = rr && ra < 12'h400 && !m_p1[2];
        logic c = rr && !b;
        logic x = xr && !rr;
        logic vf = x && m_p1[1:0] != 2'd0;
        int pg = int'(m_p1[1:0]);
        logic [7:0] cf = vf ? 8'((pg - 1) * 50 + 1) : 8'd0;
        logic [7:0] cl = vf ? 8'(pg * 50) : 8'd0;
        return {b, c, x, ra, xa, vf, (vf ? m_p1[1:0] : 2'd0), cf, cl};
    endfunction

    task automatic access(logic [7:0] a, logic rr, logic xr, string req);
        exp_t e;
        @(negedge clk);
        cpu_addr = a; rom_rd = rr; ram_rd = xr;
        e.vec = model(a, rr, xr);
        e.req = req;
        exp_q.push_back(e);
        -> sample_ev;
        #3;
    endtask

    task automatic write_p1(logic [2:0] v);
        @(negedge clk);
        p1_we = 1'b1; p1_wdata = v;
        @(negedge clk);
        p1_we = 1'b0; m_p1 = v;
    endtask

    task automatic write_p2(logic [3:0] v);
        @(negedge clk);
        p2_we = 1'b1; p2_wdata = v;
        @(negedge clk);
        p2_we = 1'b0; m_p2 = v;
    endtask

    // Monitor: take the expected item and compare it once the outputs have settled.
    initial begin
        forever begin
            @(sample_ev);
            #1;
            begin
                exp_t e = exp_q.pop_front();
                logic [43:0] act = {boot_sel, cart_sel, xram_sel, rom_addr, ram_addr,
                                    video_flag, video_bank, col_first, col_last};
                n_cmp++;
                if (act !== e.vec) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", e.req, act, e.vec);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values, read through the address outputs
        access(8'h00, 1'b1, 1'b0, "R1 reset fetch");
        access(8'h12, 1'b0, 1'b1, "R1 R8 R9 reset page 3");
        // R10 and R3: load the latches, then fetch inside the boot window
        write_p1(3'b000);
        write_p2(4'h0);
        access(8'h34, 1'b1, 1'b0, "R3 R10 boot fetch");
        write_p2(4'h3);
        access(8'hFF, 1'b1, 1'b0, "R3 boot top 3FF");
        write_p2(4'h4);
        access(8'h00, 1'b1, 1'b0, "R5 cart at 400");
        write_p2(4'hF);
        access(8'hFF, 1'b1, 1'b0, "R2 R5 cart at FFF");
        // R4: overlay turned off
        write_p1(3'b100);
        write_p2(4'h0);
        access(8'h10, 1'b1, 1'b0, "R4 cart low window");
        // R6 R8: page 0 is not video
        access(8'h80, 1'b0, 1'b1, "R6 R8 page 0");
        write_p1(3'b001);
        access(8'h05, 1'b0, 1'b1, "R9 page 1 columns");
        write_p1(3'b010);
        access(8'hC3, 1'b0, 1'b1, "R9 page 2 columns");
        // R10: a port-2 write leaves the RAM page alone
        write_p2(4'hA);
        access(8'h01, 1'b0, 1'b1, "R10 p2 write keeps page");
        // R11: both requests at once
        access(8'h22, 1'b1, 1'b1, "R11 fetch priority");
        // R7: no request
        access(8'h22, 1'b0, 1'b0, "R7 idle no select");
        // R1: reset again restores all ones
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_p1 = 3'b111; m_p2 = 4'hF;
        access(8'h00, 1'b1, 1'b0, "R1 second reset");
        #(CLK_PERIOD * 2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule